// File: doc/BRIEF.md
# Task-Switched Page Translator

This block sits between an 8-bit CPU with a 16-bit logical address bus and a 1 MB physical memory. It splits the logical space into sixteen 4 KB pages and, for each access, supplies an 8-bit physical page number. That number becomes the upper physical address bits above the 12-bit page offset. The page numbers come from a translation RAM that holds sixteen task maps of sixteen entries each. The CPU programs this RAM directly through the top 256 bytes of its own map. A small register window just below it holds the translator enable, the pending task number and a countdown that commits a task switch.

Out of reset the translator is disabled and its page output is all ones. Every logical page then lands in the highest physical 4 KB, where the startup code lives. That code fills the maps, sets the enable bit, writes the next task number, and arms the countdown. The countdown ticks on each bus-cycle strobe. When it expires, the pending task becomes active and the block drops to user mode, so the final instructions of the kernel exit still run under the system map. In user mode both windows are shut. An interrupt acknowledge returns the block to system mode with task 0.

The CPU side is a plain synchronous bus rather than a stream. There is no back-pressure: every write completes on the clock edge of its strobe cycle, and read data is combinational while the access is held. `cpu_e` marks one bus cycle per clock in which it is high.

Top module: `tsat_mmu`

## Requirements
- R1: After reset, `xlat_en` is 0, `phys_page` is 8'hFF for any logical address, the control register reads 8'h00, and the status register reads 8'h80 (system mode, task 0).
- R2: A system-mode write with `cpu_cs`, `cpu_e` high and `cpu_rw` low to address 16'hFF00 + 16*task + page stores the byte as the map entry for that task and logical page. A read of the same address with `cpu_cs` and `cpu_rw` high returns it.
- R3: While `xlat_en` is 1, `phys_page` equals the entry of the active task selected by `cpu_addr[15:12]`.
- R4: Bit 0 of the control register at 16'hFE00 is the translator enable. It reads back in bit 0, with the other bits reading 0.
- R5: Register 16'hFE01 holds the pending task in bits 3:0. Writing N to 16'hFE02 arms the countdown. On the Nth `cpu_e` cycle after that write, the pending task becomes active and the mode becomes user. Writing 0 disarms the countdown.
- R6: 16'hFE02 reads the remaining count. The status register 16'hFE03 reads the mode in bit 7 (1 = system) and the active task in bits 3:0, with the other bits 0.
- R7: In user mode, writes to 16'hFE00–16'hFFFF are ignored.
- R8: In user mode, reads anywhere in 16'hFE00–16'hFFFF return 8'hFF.
- R9: `irq_ack` high at a clock edge forces system mode and task 0, and disarms the countdown, from the next cycle on.
- R10: 16'hFE04–16'hFE06 read 8'h00 and ignore writes. Reads of other addresses, or with `cpu_cs` low, return 8'hFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cpu_addr | input | 16 | Logical CPU address |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rdata | output | 8 | Read data for the map and register windows, 8'hFF otherwise |
| cpu_rw | input | 1 | 1 = read, 0 = write |
| cpu_e | input | 1 | Bus-cycle strobe; writes and countdown ticks occur on its cycles |
| cpu_cs | input | 1 | Block select for the access |
| irq_ack | input | 1 | Interrupt acknowledge; returns to system mode, task 0 |
| phys_page | output | 8 | Physical page number (physical address bits 19:12) |
| xlat_en | output | 1 | Translator enable; 0 selects the boot mapping |

## Verification
The bound checker watches several properties on every cycle. It checks that system mode is entered only through an acknowledge and left only through an expiring countdown, and that an acknowledge always leaves task 0 active. It checks that user-mode reads of either window return 8'hFF, that user-mode writes cannot move the enable, and that the enable rises only after a control write. Only the directed scenarios can show that the right map entry reaches `phys_page`, because that depends on values the bench has written. The same holds for countdown lengths, for cancellation by a zero write or an acknowledge, and for ignored writes leaving the stored maps untouched.

// File: rtl/tsat_pkg.sv
package tsat_pkg;
  // Register offsets inside the system-register window; software decodes these.
  typedef enum logic [2:0] {
    REG_CTRL   = 3'd0,
    REG_NEXT   = 3'd1,
    REG_FUSE   = 3'd2,
    REG_STATUS = 3'd3
  } reg_offs_e;

  localparam int unsigned REG_COUNT = 7;

  typedef struct packed {
    logic       map_hit;   // map window, access permitted
    logic       reg_hit;   // register window, access permitted
    logic       wr;        // write strobe this cycle
    logic       rd;        // read in progress
    logic [7:0] offs;      // low address byte
  } bus_req_t;
endpackage

// File: rtl/tsat_decode.sv
module tsat_decode
  import tsat_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter logic [7:0]  MAP_HI = 8'hFF,
  parameter logic [7:0]  REG_HI = 8'hFE
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              cs,
  input  logic              e,
  input  logic              rw,
  input  logic              sys_mode,
  output bus_req_t          req
);
  logic map_raw, reg_raw;

  always_comb begin
    map_raw = cs && (addr[ADDR_W-1 -: 8] == MAP_HI);
    reg_raw = cs && (addr[ADDR_W-1 -: 8] == REG_HI) && (addr[7:0] < 8'(REG_COUNT));
    req.map_hit = map_raw && sys_mode;
    req.reg_hit = reg_raw && sys_mode;
    req.wr      = cs && e && !rw;
    req.rd      = cs && rw;
    req.offs    = addr[7:0];
  end
endmodule

// File: rtl/tsat_map_ram.sv
module tsat_map_ram #(
  parameter int unsigned TASKS = 16,
  parameter int unsigned PAGES = 16,
  parameter int unsigned PPN_W = 8,
  localparam int unsigned TASK_W  = $clog2(TASKS),
  localparam int unsigned PAGE_W  = $clog2(PAGES),
  localparam int unsigned IDX_W   = TASK_W + PAGE_W,
  localparam int unsigned ENTRIES = TASKS * PAGES
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  cpu_idx,
  input  logic [PPN_W-1:0]  wr_data,
  output logic [PPN_W-1:0]  cpu_q,
  input  logic [TASK_W-1:0] xl_task,
  input  logic [PAGE_W-1:0] xl_page,
  output logic [PPN_W-1:0]  xl_q
);
  logic [PPN_W-1:0] mem [ENTRIES];

  always_ff @(posedge clk) begin
    if (wr_en) mem[cpu_idx] <= wr_data;
  end

  // Two read ports: one for the CPU window, one for live translation.
  assign cpu_q = mem[cpu_idx];
  assign xl_q  = mem[{xl_task, xl_page}];
endmodule

// File: rtl/tsat_ctrl.sv
module tsat_ctrl
  import tsat_pkg::*;
#(
  parameter int unsigned TASK_W = 4,
  parameter int unsigned FUSE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              irq_ack,
  input  logic              e_tick,
  input  logic              reg_wr,
  input  logic [2:0]        reg_offs,
  input  logic [7:0]        wdata,
  output logic              xlat_en,
  output logic              sys_mode,
  output logic [TASK_W-1:0] active_task,
  output logic [TASK_W-1:0] next_task,
  output logic [FUSE_W-1:0] fuse_cnt
);
  logic wr_ctrl, wr_next, wr_fuse, fuse_done;

  assign wr_ctrl   = reg_wr && (reg_offs == REG_CTRL);
  assign wr_next   = reg_wr && (reg_offs == REG_NEXT);
  assign wr_fuse   = reg_wr && (reg_offs == REG_FUSE);
  assign fuse_done = e_tick && (fuse_cnt == FUSE_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      xlat_en   <= 1'b0;
      next_task <= '0;
    end else begin
      if (wr_ctrl) xlat_en   <= wdata[0];
      if (wr_next) next_task <= wdata[TASK_W-1:0];
    end
  end

  // Acknowledge beats everything; an arming write beats a tick in the same cycle.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sys_mode    <= 1'b1;
      active_task <= '0;
      fuse_cnt    <= '0;
    end else if (irq_ack) begin
      sys_mode    <= 1'b1;
      active_task <= '0;
      fuse_cnt    <= '0;
    end else if (wr_fuse) begin
      fuse_cnt <= wdata[FUSE_W-1:0];
    end else if (e_tick && (fuse_cnt != '0)) begin
      fuse_cnt <= fuse_cnt - FUSE_W'(1);
      if (fuse_done) begin
        active_task <= next_task;
        sys_mode    <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/tsat_mmu.sv
module tsat_mmu
  import tsat_pkg::*;
#(
  parameter int unsigned ADDR_W      = 16,
  parameter int unsigned PAGE_OFFS_W = 12,
  parameter int unsigned TASKS       = 16,
  parameter int unsigned PPN_W       = 8,
  parameter int unsigned FUSE_W      = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [7:0]        cpu_wdata,
  output logic [7:0]        cpu_rdata,
  input  logic              cpu_rw,
  input  logic              cpu_e,
  input  logic              cpu_cs,
  input  logic              irq_ack,
  output logic [PPN_W-1:0]  phys_page,
  output logic              xlat_en
);
  localparam int unsigned PAGE_W = ADDR_W - PAGE_OFFS_W;
  localparam int unsigned PAGES  = 1 << PAGE_W;
  localparam int unsigned TASK_W = $clog2(TASKS);
  localparam int unsigned IDX_W  = TASK_W + PAGE_W;

  bus_req_t          req;
  logic              sys_mode;
  logic [TASK_W-1:0] active_task, next_task;
  logic [FUSE_W-1:0] fuse_cnt;
  logic [PPN_W-1:0]  map_cpu_q, map_xl_q;
  logic [7:0]        reg_q;

  tsat_decode #(.ADDR_W(ADDR_W)) u_decode (
    .addr(cpu_addr), .cs(cpu_cs), .e(cpu_e), .rw(cpu_rw),
    .sys_mode(sys_mode), .req(req)
  );

  tsat_map_ram #(.TASKS(TASKS), .PAGES(PAGES), .PPN_W(PPN_W)) u_map (
    .clk(clk),
    .wr_en(req.map_hit && req.wr),
    .cpu_idx(req.offs[IDX_W-1:0]),
    .wr_data(cpu_wdata[PPN_W-1:0]),
    .cpu_q(map_cpu_q),
    .xl_task(active_task),
    .xl_page(cpu_addr[ADDR_W-1 -: PAGE_W]),
    .xl_q(map_xl_q)
  );

  tsat_ctrl #(.TASK_W(TASK_W), .FUSE_W(FUSE_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .irq_ack(irq_ack), .e_tick(cpu_e),
    .reg_wr(req.reg_hit && req.wr), .reg_offs(req.offs[2:0]),
    .wdata(cpu_wdata),
    .xlat_en(xlat_en), .sys_mode(sys_mode), .active_task(active_task),
    .next_task(next_task), .fuse_cnt(fuse_cnt)
  );

  always_comb begin
    case (req.offs[2:0])
      REG_CTRL:   reg_q = {7'd0, xlat_en};
      REG_NEXT:   reg_q = 8'(next_task);
      REG_FUSE:   reg_q = 8'(fuse_cnt);
      REG_STATUS: reg_q = {sys_mode, 7'(active_task)};
      default:    reg_q = 8'h00;
    endcase
  end

  always_comb begin
    if (!req.rd)          cpu_rdata = 8'hFF;
    else if (req.map_hit) cpu_rdata = 8'(map_cpu_q);
    else if (req.reg_hit) cpu_rdata = reg_q;
    else                  cpu_rdata = 8'hFF;
  end

  // Boot mapping: all ones puts every page in the top physical 4 KB.
  assign phys_page = xlat_en ? map_xl_q : '1;
endmodule

// File: rtl/tsat_mmu_chk.sv
module tsat_mmu_chk #(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned TASK_W = 4,
  parameter int unsigned FUSE_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] cpu_addr,
  input logic [7:0]        cpu_rdata,
  input logic              cpu_rw,
  input logic              cpu_e,
  input logic              cpu_cs,
  input logic              irq_ack,
  input logic              xlat_en,
  input logic              sys_mode,
  input logic [TASK_W-1:0] active_task,
  input logic [FUSE_W-1:0] fuse_cnt
);
  logic in_windows, ctrl_wr;
  assign in_windows = cpu_addr[ADDR_W-1 -: 7] == 7'h7F;
  assign ctrl_wr    = cpu_cs && cpu_e && !cpu_rw && (cpu_addr == 16'hFE00);

  assert_ack_to_system_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ack |=> (sys_mode && active_task == '0 && fuse_cnt == '0));

  assert_enter_system_only_by_ack_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sys_mode) |-> $past(irq_ack));

  assert_user_only_by_fuse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sys_mode) |-> $past(fuse_cnt == FUSE_W'(1) && cpu_e));

  assert_user_read_blocked_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!sys_mode && cpu_cs && cpu_rw && in_windows) |-> cpu_rdata == 8'hFF);

  assert_user_write_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!sys_mode && ctrl_wr) |=> $stable(xlat_en));

  assert_enable_by_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(xlat_en) |-> $past(ctrl_wr && sys_mode));
endmodule

bind tsat_mmu tsat_mmu_chk #(.ADDR_W(ADDR_W), .TASK_W(TASK_W), .FUSE_W(FUSE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_rdata(cpu_rdata),
  .cpu_rw(cpu_rw), .cpu_e(cpu_e), .cpu_cs(cpu_cs), .irq_ack(irq_ack),
  .xlat_en(xlat_en), .sys_mode(sys_mode), .active_task(active_task),
  .fuse_cnt(fuse_cnt)
);

// File: tb/tsat_mmu_tb.sv
`timescale 1ns/1ps
module tsat_mmu_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cpu_addr = '0;
  logic [7:0]  cpu_wdata = '0;
  logic [7:0]  cpu_rdata;
  logic        cpu_rw = 1'b1, cpu_e = 1'b0, cpu_cs = 1'b0, irq_ack = 1'b0;
  logic [7:0]  phys_page;
  logic        xlat_en;
  int          n_run = 0, n_fail = 0;
  logic        done = 1'b0;

  always #5 clk = ~clk;

  tsat_mmu u_dut (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_rdata(cpu_rdata), .cpu_rw(cpu_rw), .cpu_e(cpu_e), .cpu_cs(cpu_cs),
    .irq_ack(irq_ack), .phys_page(phys_page), .xlat_en(xlat_en)
  );

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %02h expected %02h", req, got, exp);
    end
  endtask

  task automatic bus_write(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    cpu_addr = a; cpu_wdata = d; cpu_rw = 1'b0; cpu_cs = 1'b1; cpu_e = 1'b1;
    @(negedge clk);
    cpu_cs = 1'b0; cpu_e = 1'b0; cpu_rw = 1'b1;
  endtask

  task automatic bus_read(input logic [15:0] a, output logic [7:0] d);
    @(negedge clk);
    cpu_addr = a; cpu_rw = 1'b1; cpu_cs = 1'b1; cpu_e = 1'b0;
    #1 d = cpu_rdata;
    cpu_cs = 1'b0;
  endtask

  task automatic read_check(input string req, input logic [15:0] a, input logic [7:0] exp);
    logic [7:0] d;
    bus_read(a, d);
    check(req, d, exp);
  endtask

  task automatic page_check(input string req, input logic [15:0] a, input logic [7:0] exp);
    @(negedge clk);
    cpu_addr = a; cpu_cs = 1'b0;
    #1 check(req, phys_page, exp);
  endtask

  task automatic idle_e(input int n);
    repeat (n) begin @(negedge clk); cpu_e = 1'b1; cpu_cs = 1'b0; end
    @(negedge clk); cpu_e = 1'b0;
  endtask

  task automatic pulse_ack();
    @(negedge clk); irq_ack = 1'b1;
    @(negedge clk); irq_ack = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 xlat_en", {7'd0, xlat_en}, 8'h00);
    page_check("R1 boot page", 16'h3000, 8'hFF);
    read_check("R1 ctrl", 16'hFE00, 8'h00);
    read_check("R1 status", 16'hFE03, 8'h80);
  endtask

  task automatic t_map_program();
    for (int p = 0; p < 16; p++) bus_write(16'hFF00 + 16'(p), 8'h10 + 8'(p));
    bus_write(16'hFF53, 8'hA3);
    read_check("R2 task0 page3", 16'hFF03, 8'h13);
    read_check("R2 task5 page3", 16'hFF53, 8'hA3);
    read_check("R2 task0 pageF", 16'hFF0F, 8'h1F);
    page_check("R1 still boot", 16'h3000, 8'hFF);
  endtask

  task automatic t_enable();
    bus_write(16'hFE00, 8'hFF);
    read_check("R4 ctrl readback", 16'hFE00, 8'h01);
    check("R4 xlat_en", {7'd0, xlat_en}, 8'h01);
    page_check("R3 task0 page3", 16'h3ABC, 8'h13);
    page_check("R3 task0 page0", 16'h0000, 8'h10);
    page_check("R3 task0 pageF", 16'hF123, 8'h1F);
  endtask

  task automatic t_fuse();
    bus_write(16'hFE01, 8'hF5);
    read_check("R5 next task", 16'hFE01, 8'h05);
    bus_write(16'hFE02, 8'h03);
    read_check("R6 count", 16'hFE02, 8'h03);
    idle_e(2);
    read_check("R6 count left", 16'hFE02, 8'h01);
    read_check("R5 still system", 16'hFE03, 8'h80);
    idle_e(1);
    page_check("R5 task5 active", 16'h3000, 8'hA3);
  endtask

  task automatic t_user_block();
    read_check("R8 map read", 16'hFF53, 8'hFF);
    read_check("R8 status read", 16'hFE03, 8'hFF);
    bus_write(16'hFE00, 8'h00);
    check("R7 enable kept", {7'd0, xlat_en}, 8'h01);
    bus_write(16'hFF53, 8'h00);
    page_check("R7 map kept", 16'h3000, 8'hA3);
  endtask

  task automatic t_ack();
    pulse_ack();
    read_check("R9 status", 16'hFE03, 8'h80);
    page_check("R9 task0 map", 16'h3000, 8'h13);
    read_check("R7 entry unchanged", 16'hFF53, 8'hA3);
  endtask

  task automatic t_cancel();
    bus_write(16'hFE02, 8'h02);
    bus_write(16'hFE02, 8'h00);
    idle_e(4);
    read_check("R5 zero disarms", 16'hFE03, 8'h80);
    bus_write(16'hFE02, 8'h03);
    pulse_ack();
    read_check("R9 count cleared", 16'hFE02, 8'h00);
    idle_e(4);
    read_check("R9 ack disarms", 16'hFE03, 8'h80);
  endtask

  task automatic t_reserved();
    read_check("R10 reserved", 16'hFE05, 8'h00);
    bus_write(16'hFE05, 8'h5A);
    read_check("R10 reserved write", 16'hFE05, 8'h00);
    read_check("R10 past regs", 16'hFE07, 8'hFF);
    read_check("R10 outside", 16'h1234, 8'hFF);
    @(negedge clk);
    cpu_addr = 16'hFF03; cpu_rw = 1'b1; cpu_cs = 1'b0;
    #1 check("R10 cs low", cpu_rdata, 8'hFF);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: got hang expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_map_program();
    t_enable();
    t_fuse();
    t_user_block();
    t_ack();
    t_cancel();
    t_reserved();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule